// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a synchronous DRAM burst. A controller pulses `start` with the first column, the burst length code, the ordering choice and the access direction. The block then presents one column per beat. It moves to the next beat on each cycle in which `advance` is high. Flags mark the first and the last beat. The burst ends after its final beat, when `stop` is raised, or when a new `start` replaces it.

Finite bursts of 1, 2, 4 or 8 words stay inside an aligned block whose base is a multiple of the length. Sequential ordering counts upward and wraps inside that block. Interleaved ordering XORs the beat number into the low column bits. A full-row burst has no end of its own: it counts through the row, wraps from the top column to column 0, and runs until it is stopped. When the single-location write bit is set, a write is a one-beat access whatever the length code says. Length codes that name no length are refused and flagged.

Top module: `burst_col_seq`

## Requirements
- R1: While and directly after reset, `active`, `first_beat`, `last_beat` and `code_err` are 0 and `col_addr` is 0.
- R2: In every beat of a finite burst, the column bits above log2(length) equal those of the start column, so the burst stays in its aligned block.
- R3: A finite burst of length N shows exactly N beats. `first_beat` is set on beat 0 and `last_beat` on beat N-1. `active` falls in the cycle after an advance on the last beat. With length 1 (code 000), both flags are set on the single beat.
- R4: With `interleave`=0, beat k shows block_base + ((start mod N) + k) mod N. For example, start 6 with length 4 (code 010) gives 6,7,4,5.
- R5: With `interleave`=1, beat k shows the start column with its low log2(N) bits XORed by k. Start 5 gives 5,4,7,6 at length 4 and 5,4,7,6,1,0,3,2 at length 8 (code 011).
- R6: With length 2 (code 001), the requested column comes first and the other column of its aligned pair comes second, in both orderings.
- R7: Code 111 starts a full-row burst. Its column rises by one on each advance, wraps from 2^COL_W-1 to 0, and never raises `last_beat`.
- R8: `stop` during a burst clears `active`, `first_beat` and `last_beat` in the next cycle, and `col_addr` keeps its last value.
- R9: When `is_write`=1 and `wr_single`=1 at start, the burst is one beat long whatever `bl_code` says. When `wr_single`=0, a write follows `bl_code` and `interleave`.
- R10: A start with a reserved code (100, 101, 110), and no single-location write in force, starts no burst and sets `code_err`. `code_err` stays set until the next accepted start clears it.
- R11: While `advance` is 0 during a burst, `col_addr`, the flags and `active` hold.
- R12: `start` has priority over `stop` and `advance`. A start during a burst restarts at beat 0 with the new start column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a burst with the fields below |
| start_col | input | COL_W | Requested first column |
| bl_code | input | 3 | Length code: 000=1, 001=2, 010=4, 011=8, 111=full row |
| interleave | input | 1 | 0 = sequential order, 1 = interleaved order |
| is_write | input | 1 | Access at start is a write |
| wr_single | input | 1 | Single-location write mode bit |
| advance | input | 1 | Move to the next beat |
| stop | input | 1 | End the current burst |
| col_addr | output | COL_W | Column of the current beat (registered) |
| active | output | 1 | A burst beat is being presented |
| first_beat | output | 1 | Current beat is beat 0 |
| last_beat | output | 1 | Current beat is the final beat of a finite burst |
| code_err | output | 1 | Last start carried a reserved length code |

## Verification
On every cycle, the embedded properties check the following. Finite bursts never leave their aligned block from one beat to the next. A full-row burst steps by exactly one column per advance. A stalled beat holds. Stop and the final advance both end the burst in the next cycle. An error flag never coexists with an active burst. The exact ordering of columns needs the bench's behavioural model, which is compared every clock: 6,7,4,5 for sequential length 4, the interleaved 5-4-7-6-1-0-3-2, and the wrap at the top of the row. The model also covers the override by single-location writes, the restart priority and the refusal of reserved codes.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef struct packed {
    logic [1:0] lg;    // log2 of finite burst length
    logic       full;  // open-ended row burst
    logic       bad;   // reserved length code
  } blen_t;

  function automatic logic [2:0] beat_lim(input logic [1:0] lg);
    return 3'((4'd1 << lg) - 4'd1);
  endfunction
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
  import bcs_pkg::*;
(
  input  logic [2:0] bl_code,
  input  logic       is_write,
  input  logic       wr_single,
  output blen_t      dec
);
  always_comb begin
    dec = '0;
    if (is_write && wr_single) begin
      dec.lg = 2'd0;
    end else begin
      unique case (bl_code)
        3'b000:  dec.lg = 2'd0;
        3'b001:  dec.lg = 2'd1;
        3'b010:  dec.lg = 2'd2;
        3'b011:  dec.lg = 2'd3;
        3'b111:  dec.full = 1'b1;
        default: dec.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] cnt,
  input  logic [1:0]       lg,
  input  logic             full,
  input  logic             interleave,
  output logic [COL_W-1:0] col
);
  localparam int LOW_W = 3;

  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    if (i < LOW_W) begin : g_low
      assign mask[i] = (lg > 2'(i));
    end else begin : g_high
      assign mask[i] = 1'b0;
    end
  end

  assign sum     = base + cnt;
  assign seq_col = (base & ~mask) | (sum & mask);
  assign ilv_col = base ^ (cnt & mask);
  assign col     = full ? sum : (interleave ? ilv_col : seq_col);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             interleave,
  input  logic             is_write,
  input  logic             wr_single,
  input  logic             advance,
  input  logic             stop,
  output logic [COL_W-1:0] col_addr,
  output logic             active,
  output logic             first_beat,
  output logic             last_beat,
  output logic             code_err
);
  blen_t            dec;
  logic [COL_W-1:0] base_q, cnt_q, cnt_nxt, col_nxt, lim_q;
  logic [1:0]       lg_q;
  logic             full_q, ilv_q;

  bcs_len_decode u_dec (
    .bl_code  (bl_code),
    .is_write (is_write),
    .wr_single(wr_single),
    .dec      (dec)
  );

  assign cnt_nxt = cnt_q + COL_W'(1);
  assign lim_q   = COL_W'(beat_lim(lg_q));

  bcs_addr_gen #(.COL_W(COL_W)) u_gen (
    .base      (base_q),
    .cnt       (cnt_nxt),
    .lg        (lg_q),
    .full      (full_q),
    .interleave(ilv_q),
    .col       (col_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      cnt_q      <= '0;
      lg_q       <= '0;
      full_q     <= 1'b0;
      ilv_q      <= 1'b0;
      col_addr   <= '0;
      active     <= 1'b0;
      first_beat <= 1'b0;
      last_beat  <= 1'b0;
      code_err   <= 1'b0;
    end else if (start) begin
      first_beat <= !dec.bad;
      active     <= !dec.bad;
      code_err   <= dec.bad;
      last_beat  <= !dec.bad && !dec.full && (dec.lg == 2'd0);
      if (!dec.bad) begin
        base_q   <= start_col;
        cnt_q    <= '0;
        lg_q     <= dec.lg;
        full_q   <= dec.full;
        ilv_q    <= interleave;
        col_addr <= start_col;
      end
    end else if (active && stop) begin
      active     <= 1'b0;
      first_beat <= 1'b0;
      last_beat  <= 1'b0;
    end else if (active && advance) begin
      first_beat <= 1'b0;
      if (last_beat) begin
        active    <= 1'b0;
        last_beat <= 1'b0;
      end else begin
        cnt_q     <= cnt_nxt;
        col_addr  <= col_nxt;
        last_beat <= !full_q && (cnt_nxt == lim_q);
      end
    end
  end

  // R2
  block_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    active && advance && !stop && !start && !last_beat && !full_q |=>
      ((col_addr ^ $past(col_addr)) & ~$past(lim_q)) == '0);

  // R7
  full_step_chk: assert property (@(posedge clk) disable iff (rst)
    active && advance && !stop && !start && full_q |=>
      col_addr == $past(col_addr) + COL_W'(1) && !last_beat);

  // R3
  last_end_chk: assert property (@(posedge clk) disable iff (rst)
    active && advance && last_beat && !stop && !start |=> !active);

  // R8
  stop_end_chk: assert property (@(posedge clk) disable iff (rst)
    active && stop && !start |=> !active && $stable(col_addr));

  // R10
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    code_err |-> !active);

  // R11
  hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
    active && !advance && !stop && !start |=>
      active && $stable(col_addr) && $stable(last_beat));
endmodule

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb_top;
  localparam int COL_W = 8;
  localparam int NCOL  = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, advance = 1'b0, stop = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0] bl_code = '0;
  logic interleave = 1'b0, is_write = 1'b0, wr_single = 1'b0;
  logic [COL_W-1:0] col_addr;
  logic active, first_beat, last_beat, code_err;

  int total = 0, bad = 0;
  int m_act = 0, m_base = 0, m_cnt = 0, m_len = 1, m_col = 0;
  int m_first = 0, m_last = 0, m_err = 0, m_il = 0;

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .bl_code(bl_code), .interleave(interleave), .is_write(is_write),
    .wr_single(wr_single), .advance(advance), .stop(stop),
    .col_addr(col_addr), .active(active), .first_beat(first_beat),
    .last_beat(last_beat), .code_err(code_err)
  );

  function automatic int mcol(int b, int c, int len, int il);
    int blk;
    if (len == 0) return (b + c) % NCOL;
    blk = b - (b % len);
    if (il != 0) return blk + ((b % len) ^ c);
    return blk + ((b % len) + c) % len;
  endfunction

  // one clock: apply inputs, step model, compare after the edge
  task automatic cyc(input logic s, input logic adv, input logic stp, input string tag);
    int len;
    start = s; advance = adv; stop = stp;
    if (rst) begin
      m_act = 0; m_col = 0; m_first = 0; m_last = 0; m_err = 0; m_cnt = 0;
    end else if (s) begin
      len = -1;
      if (is_write && wr_single) len = 1;
      else case (bl_code)
        3'b000: len = 1;
        3'b001: len = 2;
        3'b010: len = 4;
        3'b011: len = 8;
        3'b111: len = 0;
        default: len = -1;
      endcase
      if (len < 0) begin
        m_act = 0; m_first = 0; m_last = 0; m_err = 1;
      end else begin
        m_act = 1; m_first = 1; m_last = (len == 1); m_err = 0;
        m_base = int'(start_col); m_cnt = 0; m_len = len;
        m_il = int'(interleave); m_col = m_base;
      end
    end else if (m_act != 0 && stp) begin
      m_act = 0; m_first = 0; m_last = 0;
    end else if (m_act != 0 && adv) begin
      m_first = 0;
      if (m_last != 0) begin
        m_act = 0; m_last = 0;
      end else begin
        m_cnt++;
        m_col = mcol(m_base, m_cnt, m_len, m_il);
        m_last = (m_len != 0 && m_cnt == m_len - 1);
      end
    end
    @(posedge clk);
    @(negedge clk);
    total++;
    if (int'(col_addr) != m_col || int'(active) != m_act || int'(first_beat) != m_first ||
        int'(last_beat) != m_last || int'(code_err) != m_err) begin
      bad++;
      $display("FAIL %s: actual col=%0d act=%0b first=%0b last=%0b err=%0b expected col=%0d act=%0d first=%0d last=%0d err=%0d",
               tag, col_addr, active, first_beat, last_beat, code_err,
               m_col, m_act, m_first, m_last, m_err);
    end
  endtask

  task automatic setup(input logic [2:0] code, input int col, input logic il,
                       input logic wr, input logic ws);
    bl_code = code; start_col = COL_W'(col); interleave = il;
    is_write = wr; wr_single = ws;
  endtask

  task automatic run(input int nadv, input string tag);
    cyc(1'b1, 1'b0, 1'b0, tag);
    for (int i = 0; i < nadv; i++) cyc(1'b0, 1'b1, 1'b0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(1'b0, 1'b0, 1'b0, "R1");
    cyc(1'b0, 1'b0, 1'b0, "R1");
    rst = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, "R1");

    setup(3'b010, 6, 1'b0, 1'b0, 1'b0); run(5, "R4");
    setup(3'b010, 4, 1'b0, 1'b0, 1'b0); run(4, "R4");
    setup(3'b010, 5, 1'b1, 1'b0, 1'b0); run(5, "R5");
    setup(3'b011, 5, 1'b1, 1'b0, 1'b0); run(9, "R5");
    setup(3'b011, 8'h1d, 1'b0, 1'b0, 1'b0); run(9, "R2");
    setup(3'b011, 8'hea, 1'b1, 1'b0, 1'b0); run(9, "R2");
    setup(3'b001, 3, 1'b0, 1'b0, 1'b0); run(3, "R6");
    setup(3'b001, 2, 1'b1, 1'b0, 1'b0); run(3, "R6");
    setup(3'b000, 9, 1'b0, 1'b0, 1'b0); run(2, "R3");
    setup(3'b000, 9, 1'b0, 1'b0, 1'b0); run(0, "R3");
    cyc(1'b0, 1'b0, 1'b0, "R3");
    cyc(1'b0, 1'b1, 1'b0, "R3");
    cyc(1'b0, 1'b1, 1'b0, "R3");

    // stalls inside a length-8 burst
    setup(3'b011, 8'h32, 1'b0, 1'b0, 1'b0); run(2, "R11");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, "R11");
    for (int i = 0; i < 7; i++) cyc(1'b0, (i % 2) == 0, 1'b0, "R11");

    // full row, wrap at top
    setup(3'b111, 253, 1'b0, 1'b0, 1'b0); run(8, "R7");
    for (int i = 0; i < 2; i++) cyc(1'b0, 1'b0, 1'b0, "R7");
    cyc(1'b0, 1'b1, 1'b1, "R8");
    cyc(1'b0, 1'b1, 1'b0, "R8");
    setup(3'b111, 100, 1'b1, 1'b0, 1'b0); run(3, "R7");
    cyc(1'b0, 1'b0, 1'b1, "R8");

    // stop mid finite burst
    setup(3'b011, 16, 1'b0, 1'b0, 1'b0); run(3, "R8");
    cyc(1'b0, 1'b1, 1'b1, "R8");
    cyc(1'b0, 1'b1, 1'b0, "R8");

    // write modes
    setup(3'b011, 42, 1'b0, 1'b1, 1'b1); run(3, "R9");
    setup(3'b101, 42, 1'b0, 1'b1, 1'b1); run(2, "R9");
    setup(3'b010, 42, 1'b1, 1'b1, 1'b0); run(5, "R9");
    setup(3'b011, 42, 1'b0, 1'b0, 1'b1); run(9, "R9");

    // reserved codes
    setup(3'b100, 70, 1'b0, 1'b0, 1'b0); run(2, "R10");
    setup(3'b110, 71, 1'b0, 1'b0, 1'b0); run(1, "R10");
    setup(3'b001, 72, 1'b0, 1'b0, 1'b0); run(1, "R10");
    setup(3'b010, 80, 1'b0, 1'b0, 1'b0); run(2, "R10");
    setup(3'b101, 90, 1'b0, 1'b0, 1'b0); run(2, "R10");

    // restart priority
    setup(3'b011, 120, 1'b0, 1'b0, 1'b0); run(3, "R12");
    setup(3'b010, 33, 1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b1, "R12");
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0, "R12");
    cyc(1'b0, 1'b0, 1'b0, "R12");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule